// File: doc/BRIEF.md
# Segmented Current-Cell Switch Decoder

This block turns a 14-bit converter code into the switch controls of a segmented current-steering array. The code is cut into three groups. The top five bits and the middle five bits each become a 31-cell thermometer word. Each of these words is built by a row decoder and a column decoder, and every cell combines one row term with one column term. The low four bits stay binary and drive four binary-weighted cells. All 66 cell controls share one vector. Cells 0 to 30 belong to the top group, cells 31 to 61 to the middle group and cells 62 to 65 to the low bits.

The control vector is retimed through two register stages in series, so every cell control changes on the same clock edge. A second copy of the vector is retimed by falling-edge stages and trails the first copy by half a clock period. For each copy, every cell control is expanded into a four-switch drive nibble. Two switches steer the cell current to the positive or the negative output, and two are held permanently off. When a control changes, exactly two switches toggle.

Top module: `seg_cell_decoder`

## Requirements
- R1: The code splits as code_i[13:9] (top group, value H), code_i[8:4] (middle group, value M) and code_i[3:0] (low bits).
- R2: Top-group cell k (0..30, vector index k) is on exactly when k < H. H=0 turns on no cell and H=31 turns on all 31 cells.
- R3: Middle-group cell k (vector index 31+k) is on exactly when k < M. The cell sits at row k/8 and column k%8, and is on when its row is below M[4:3], or when its row equals M[4:3] and its column is below M[2:0].
- R4: Vector index 62+i carries code_i[i] for i = 0..3.
- R5: The lead copy shows the code sampled at rising edge t after rising edge t+1. All 66 controls change on that same edge.
- R6: The lag copy takes the lead copy's value at the falling edge that follows, so it trails the lead copy by half a period.
- R7: Nibble j of each switch output (bits 4j+3..4j) is {0, 0, ~c, c}, where c is control j. Bit 4j steers to the positive output and bit 4j+1 steers to the negative output.
- R8: The on-cells of the lead copy, weighted 512 (top group), 16 (middle group) and 8/4/2/1 (index 65..62), sum to the code that was sampled two rising edges earlier.
- R9: While rst_ni is low, every control in both copies is off, so every nibble reads 4'b0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock; the lead copy uses rising edges, the lag copy falling edges |
| rst_ni | input | 1 | Active-low asynchronous reset |
| code_i | input | 14 | Converter code |
| lead_sw_o | output | 264 | Four-switch nibbles of the lead copy, nibble j for cell j |
| lag_sw_o | output | 264 | Four-switch nibbles of the lag copy, half a period behind |

## Verification
The bench builds the block with its default parameters: five-bit unary groups split into 2 row bits and 3 column bits, and a four-bit binary tail. With this configuration all 16384 codes are within reach of an exhaustive sweep. For each code, every group slice, the switch nibbles and the weighted sum are compared with values computed from the code alone. The lag copy is sampled both just after the rising edge, when it must still hold the previous code, and just after the following falling edge, when it must have caught up. This exposes any error in alignment or half-cycle phase across every code-to-code transition of the sweep.

// File: rtl/celldec_pkg.sv
`timescale 1ns/1ps
package celldec_pkg;
  localparam int SW_PER_CELL = 4;

  typedef enum int {
    SW_POS    = 0,
    SW_NEG    = 1,
    SW_IDLE_A = 2,
    SW_IDLE_B = 3
  } sw_slot_e;

  // weight of cell idx in a hi/mid unary + lo binary layout
  function automatic int cell_weight(int idx, int hi_n, int mid_n, int mid_w, int lo_w);
    if (idx < hi_n) return 1 << (mid_w + lo_w);
    if (idx < hi_n + mid_n) return 1 << lo_w;
    return 1 << (idx - hi_n - mid_n);
  endfunction
endpackage

// File: rtl/therm_rc_decoder.sv
`timescale 1ns/1ps
module therm_rc_decoder #(
  parameter  int GRP_W = 5,
  parameter  int COL_W = 3,
  localparam int N     = 2**GRP_W - 1
) (
  input  logic [GRP_W-1:0] grp_i,
  output logic [N-1:0]     cell_o
);
  localparam int ROW_W = GRP_W - COL_W;
  localparam int ROWS  = 2**ROW_W;
  localparam int COLS  = 2**COL_W;

  logic [ROW_W-1:0] row_idx;
  logic [COL_W-1:0] col_idx;
  logic [ROWS-1:0]  row_full, row_eq;
  logic [COLS-1:0]  col_lt;

  assign row_idx = grp_i[GRP_W-1:COL_W];
  assign col_idx = grp_i[COL_W-1:0];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_full[r] = row_idx > ROW_W'(r);
    assign row_eq[r]   = row_idx == ROW_W'(r);
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_lt[c] = col_idx > COL_W'(c);
  end

  // same two-level gate per cell keeps depth uniform
  for (genvar k = 0; k < N; k++) begin : g_cell
    assign cell_o[k] = row_full[k / COLS] | (row_eq[k / COLS] & col_lt[k % COLS]);
  end

  always_comb begin
    if (!$isunknown(grp_i)) begin
      a_r2_count_matches: assert ($countones(cell_o) == int'(grp_i));
      a_r3_therm_shape: assert ((({1'b0, cell_o} + 1'b1) & {1'b0, cell_o}) == '0);
    end
  end
endmodule

// File: rtl/dual_phase_retime.sv
`timescale 1ns/1ps
module dual_phase_retime #(
  parameter int W = 66
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lead_o,
  output logic [W-1:0] lag_o
);
  logic [W-1:0] lead_s1_q, lead_s2_q, lag_s1_q, lag_s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lead_s1_q <= '0;
      lead_s2_q <= '0;
    end else begin
      lead_s1_q <= d_i;
      lead_s2_q <= lead_s1_q;
    end
  end

  // lag copy picks up the lead first stage half a cycle later
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lag_s1_q <= '0;
      lag_s2_q <= '0;
    end else begin
      lag_s1_q <= lead_s1_q;
      lag_s2_q <= lag_s1_q;
    end
  end

  assign lead_o = lead_s2_q;
  assign lag_o  = lag_s2_q;

  a_r6_aligned_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lag_o == lead_o);
  a_r6_follows_at_fall: assert property (@(negedge clk_i) disable iff (!rst_ni)
    lag_o == $past(lead_o));
endmodule

// File: rtl/quad_switch_map.sv
`timescale 1ns/1ps
module quad_switch_map import celldec_pkg::*; #(
  parameter int N = 66
) (
  input  logic [N-1:0]             ctrl_i,
  output logic [N*SW_PER_CELL-1:0] sw_o
);
  for (genvar j = 0; j < N; j++) begin : g_cell
    assign sw_o[SW_PER_CELL*j + SW_POS]    = ctrl_i[j];
    assign sw_o[SW_PER_CELL*j + SW_NEG]    = ~ctrl_i[j];
    assign sw_o[SW_PER_CELL*j + SW_IDLE_A] = 1'b0;
    assign sw_o[SW_PER_CELL*j + SW_IDLE_B] = 1'b0;
  end
endmodule

// File: rtl/seg_cell_decoder.sv
`timescale 1ns/1ps
module seg_cell_decoder import celldec_pkg::*; #(
  parameter  int HI_W   = 5,
  parameter  int MID_W  = 5,
  parameter  int LO_W   = 4,
  parameter  int COL_W  = 3,
  localparam int CODE_W = HI_W + MID_W + LO_W,
  localparam int HI_N   = 2**HI_W - 1,
  localparam int MID_N  = 2**MID_W - 1,
  localparam int CELLS  = HI_N + MID_N + LO_W,
  localparam int SW_W   = CELLS * SW_PER_CELL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic [SW_W-1:0]   lead_sw_o,
  output logic [SW_W-1:0]   lag_sw_o
);
  logic [CELLS-1:0] ctrl_raw, lead_ctrl, lag_ctrl;

  therm_rc_decoder #(.GRP_W(HI_W), .COL_W(COL_W)) u_hi_dec (
    .grp_i  (code_i[CODE_W-1 -: HI_W]),
    .cell_o (ctrl_raw[HI_N-1:0])
  );

  therm_rc_decoder #(.GRP_W(MID_W), .COL_W(COL_W)) u_mid_dec (
    .grp_i  (code_i[LO_W +: MID_W]),
    .cell_o (ctrl_raw[HI_N +: MID_N])
  );

  // binary tail shares the retime path, so latency matches the unary cells
  assign ctrl_raw[HI_N+MID_N +: LO_W] = code_i[LO_W-1:0];

  dual_phase_retime #(.W(CELLS)) u_retime (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ctrl_raw),
    .lead_o (lead_ctrl),
    .lag_o  (lag_ctrl)
  );

  quad_switch_map #(.N(CELLS)) u_lead_map (
    .ctrl_i (lead_ctrl),
    .sw_o   (lead_sw_o)
  );

  quad_switch_map #(.N(CELLS)) u_lag_map (
    .ctrl_i (lag_ctrl),
    .sw_o   (lag_sw_o)
  );

  // self-check support
  logic [1:0] warm_q;
  int         lead_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  always_comb begin
    lead_sum = 0;
    for (int j = 0; j < CELLS; j++)
      if (lead_ctrl[j]) lead_sum += cell_weight(j, HI_N, MID_N, MID_W, LO_W);
  end

  a_r5_two_stage_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> lead_ctrl == $past(ctrl_raw, 2));
  a_r8_weighted_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> lead_sum == int'($past(code_i, 2)));
  a_r7_two_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lead_sw_o ^ $past(lead_sw_o)) == 2 * $countones(lead_ctrl ^ $past(lead_ctrl)));
  a_r9_reset_off: assert property (@(posedge clk_i)
    !rst_ni |-> (lead_ctrl == '0 && lag_ctrl == '0));
endmodule

// File: tb/seg_cell_decoder_bench.sv
`timescale 1ns/1ps
module seg_cell_decoder_bench;
  localparam int CELLS = 66;
  localparam int SW_W  = 4 * CELLS;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [13:0]     code_i = '0;
  logic [SW_W-1:0] lead_sw_o, lag_sw_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  seg_cell_decoder u_seg_cell_decoder (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (code_i),
    .lead_sw_o (lead_sw_o),
    .lag_sw_o  (lag_sw_o)
  );

  function automatic logic [CELLS-1:0] exp_cells(logic [13:0] c);
    logic [CELLS-1:0] v;
    v = '0;
    for (int k = 0; k < 31; k++) begin
      v[k]      = k < int'(c[13:9]);
      v[31 + k] = k < int'(c[8:4]);
    end
    for (int i = 0; i < 4; i++) v[62 + i] = c[i];
    return v;
  endfunction

  function automatic logic [SW_W-1:0] exp_sw(logic [CELLS-1:0] v);
    logic [SW_W-1:0] s;
    for (int j = 0; j < CELLS; j++) s[4*j +: 4] = {2'b00, ~v[j], v[j]};
    return s;
  endfunction

  function automatic logic [CELLS-1:0] pos_bits(logic [SW_W-1:0] s);
    logic [CELLS-1:0] v;
    for (int j = 0; j < CELLS; j++) v[j] = s[4*j];
    return v;
  endfunction

  function automatic int wsum(logic [SW_W-1:0] s);
    int t;
    t = 0;
    for (int j = 0; j < CELLS; j++)
      if (s[4*j]) t += (j < 31) ? 512 : (j < 62) ? 16 : (1 << (j - 62));
    return t;
  endfunction

  task automatic chk(string req, logic [SW_W-1:0] act, logic [SW_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [13:0] c, logic [13:0] prev);
    logic [CELLS-1:0] cells, got;
    cells = exp_cells(c);
    @(negedge clk_i);
    code_i = c;
    @(posedge clk_i);
    @(posedge clk_i);
    #1;
    got = pos_bits(lead_sw_o);
    chk("R1 R2 hi group", SW_W'(got[30:0]), SW_W'(cells[30:0]));
    chk("R3 mid group", SW_W'(got[61:31]), SW_W'(cells[61:31]));
    chk("R4 low bits", SW_W'(got[65:62]), SW_W'(c[3:0]));
    chk("R5 R7 lead nibbles", lead_sw_o, exp_sw(cells));
    chk("R8 weighted sum", SW_W'(wsum(lead_sw_o)), SW_W'(c));
    chk("R6 lag holds previous", lag_sw_o, exp_sw(exp_cells(prev)));
    @(negedge clk_i);
    #1;
    chk("R6 lag caught up", lag_sw_o, exp_sw(cells));
  endtask

  initial begin
    logic [13:0] prev;
    #9;
    chk("R9 lead in reset", lead_sw_o, exp_sw('0));
    chk("R9 lag in reset", lag_sw_o, exp_sw('0));
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    prev = '0;
    for (int c = 0; c < 16384; c++) begin
      apply(14'(c), prev);
      prev = 14'(c);
    end
    // corner jumps: full scale to zero and back, group carries
    apply(14'h3FFF, prev);
    apply(14'h0000, 14'h3FFF);
    apply(14'h3FFF, 14'h0000);
    apply(14'h01FF, 14'h3FFF);
    apply(14'h0200, 14'h01FF);
    apply(14'h000F, 14'h0200);
    apply(14'h0010, 14'h000F);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule